// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block carries out a multi-cycle push of a selected set of general registers onto a descending stack. It supports two kinds of operation. A frame-prepare operation saves any of r20..r31 and then reserves extra frame space. A push-multiple operation saves any of r1..r15, and can also save the current status word and a return PC/status pair.

A one-cycle `start` pulse hands the block a mode, a 32-bit list word, the stack pointer and two exception-state flags. The block then visits the selected registers in ascending register number. For each one it reads the register file through a combinational read port and issues one 32-bit write on a valid/ready store port. The stack pointer drops by 4 before every store. When the sequence ends, the block drives the final stack pointer on `sp_out` and raises `done` for one cycle.

Top module: `regpush_seq`

## Requirements
- R1: With `mode`=0 (frame-prepare), the list-word bit positions 27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 0, 21 select registers r20, r21, ... r31 in that order.
- R2: Selected registers are stored one per accepted transfer in ascending register number. Each store address is 4 below the previous stack pointer, so a lower register lands at a higher address. `st_data` is the value read at `rf_addr` = the register number.
- R3: In frame-prepare mode, `sp_out` equals the stack pointer after the last store minus 4 times list-word bits [5:1]. Store addresses in this mode are not realigned.
- R4: With `mode`=1 (push-multiple), the list-word bit positions 2, 1, 0, 27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 20, 21 select registers r1, r2, ... r15 in that order.
- R5: In push-multiple mode, list bit 3 adds one store of `stat_word` after all register stores.
- R6: In push-multiple mode, list bit 19 adds two final stores covering 8 bytes. The return PC goes to the higher address (final SP + 4) and the return status goes to the final SP.
- R7: The fatal pair (`fatal_ret_pc`/`fatal_ret_stat`) is stored when `in_fatal`=1 and `in_exc`=0. In every other combination the interrupt pair (`intr_ret_pc`/`intr_ret_stat`) is stored.
- R8: Every push-multiple store address has bits [1:0] cleared. `sp_out` is the unaligned running value.
- R9: A list that selects nothing makes no store and raises `done` no later than the second clock edge after the edge that accepts `start`. `sp_out` is then `sp_in` minus the frame adjustment (frame-prepare) or `sp_in` itself (push-multiple).
- R10: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `st_data` hold unchanged into the next cycle.
- R11: A `start` pulse that arrives while `busy` is high has no effect on the stores, on `done` or on `sp_out`.
- R12: After reset `busy`, `done` and `st_valid` are low. `done` is a single-cycle pulse, and `sp_out` keeps its value after `done` until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 1 | 0 = frame-prepare, 1 = push-multiple |
| list_word | input | 32 | Scattered register selection, immediate and extra-word flags |
| sp_in | input | 32 | Stack pointer at start |
| in_fatal | input | 1 | Fatal-exception state flag |
| in_exc | input | 1 | Exception-in-progress flag |
| stat_word | input | 32 | Current status word |
| fatal_ret_pc | input | 32 | Return PC saved on fatal exception |
| fatal_ret_stat | input | 32 | Status saved on fatal exception |
| intr_ret_pc | input | 32 | Return PC saved on interrupt |
| intr_ret_stat | input | 32 | Status saved on interrupt |
| rf_addr | output | 5 | Register-file read address |
| rf_data | input | 32 | Register-file read data (combinational) |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store accepted |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Final stack pointer |

## Verification
Two functions can fall in the same cycle: a store stall and a new `start` pulse. While the store port withholds ready and a request is pending, the bench drives `start` with a different mode, an all-ones list and another stack pointer. It then judges that the held request stays stable and that the store stream matches the first operation only. It also checks that exactly one `done` pulse occurs and that `sp_out` carries the first operation's value. Stalls are also laid over the long push sequences, where the status word and the return pair follow the registers. This checks that the hand-off from register data to the latched words survives back-pressure.

// File: rtl/regpush_seq.sv
module regpush_seq #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [31:0]   list_word,
  input  logic [DW-1:0] sp_in,
  input  logic          in_fatal,
  input  logic          in_exc,
  input  logic [DW-1:0] stat_word,
  input  logic [DW-1:0] fatal_ret_pc,
  input  logic [DW-1:0] fatal_ret_stat,
  input  logic [DW-1:0] intr_ret_pc,
  input  logic [DW-1:0] intr_ret_stat,
  output logic [RW-1:0] rf_addr,
  input  logic [DW-1:0] rf_data,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [DW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] sp_out
);
  localparam int NFR = 12;
  localparam int NPM = 15;
  localparam int NI  = NPM + 3;
  localparam int I_STAT = NPM;
  localparam int I_PC   = NPM + 1;
  localparam int I_RST  = NPM + 2;
  localparam int FR_POS [NFR] = '{27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 0, 21};
  localparam int PM_POS [NPM] = '{2, 1, 0, 27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 20, 21};

  logic [NI-1:0] sel_init, pend;
  logic [DW-1:0] sp_q, stat_q, pc_q, rst_q, nxt_sp;
  logic [4:0]    adj_q, cur;
  logic          mode_q;
  logic          unused_bits;

  assign unused_bits = ^list_word[18:6];

  always_comb begin
    sel_init = '0;
    if (mode) begin
      for (int i = 0; i < NPM; i++) sel_init[i] = list_word[PM_POS[i]];
      sel_init[I_STAT] = list_word[3];
      sel_init[I_PC]   = list_word[19];
      sel_init[I_RST]  = list_word[19];
    end else begin
      for (int i = 0; i < NFR; i++) sel_init[i] = list_word[FR_POS[i]];
    end
  end

  always_comb begin
    cur = '0;
    for (int i = NI - 1; i >= 0; i--) if (pend[i]) cur = 5'(i);
  end

  assign nxt_sp   = sp_q - DW'(4);
  assign st_valid = busy && (pend != '0);
  assign st_addr  = mode_q ? {nxt_sp[DW-1:2], 2'b00} : nxt_sp;
  assign rf_addr  = mode_q ? RW'(cur + 5'd1) : RW'(cur + 5'd20);

  always_comb begin
    case (cur)
      5'(I_STAT): st_data = stat_q;
      5'(I_PC):   st_data = pc_q;
      5'(I_RST):  st_data = rst_q;
      default:    st_data = rf_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; pend <= '0; sp_q <= '0; sp_out <= '0;
      mode_q <= 1'b0; adj_q <= '0; stat_q <= '0; pc_q <= '0; rst_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          pend   <= sel_init;
          sp_q   <= sp_in;
          mode_q <= mode;
          adj_q  <= mode ? 5'd0 : list_word[5:1];
          stat_q <= stat_word;
          pc_q   <= (in_fatal && !in_exc) ? fatal_ret_pc   : intr_ret_pc;
          rst_q  <= (in_fatal && !in_exc) ? fatal_ret_stat : intr_ret_stat;
        end
      end else if (pend != '0) begin
        if (st_ready) begin
          pend <= pend & (pend - NI'(1));
          sp_q <= nxt_sp;
        end
      end else begin
        busy   <= 1'b0;
        done   <= 1'b1;
        sp_out <= sp_q - {{(DW-7){1'b0}}, adj_q, 2'b00};
      end
    end
  end

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

  a_r8_push_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && mode_q |-> st_addr[1:0] == 2'b00);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready ##1 st_valid |-> st_addr == $past(st_addr) - DW'(4));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && $stable(sp_out));

  a_r11_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && st_valid && start |=> busy && $stable(mode_q));

  a_r9_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

// File: tb/tb_regpush_seq.sv
`timescale 1ns/1ps
module tb_regpush_seq;
  logic clk = 0, rst_n = 0, start = 0, mode = 0, in_fatal = 0, in_exc = 0, st_ready = 1;
  logic [31:0] list_word = 0, sp_in = 0, rf_data, st_addr, st_data, sp_out;
  logic [4:0]  rf_addr;
  logic        st_valid, busy, done;
  localparam logic [31:0] STATW = 32'h5555_0003, FPC = 32'hF0F0_1000, FST = 32'hF0F0_2000,
                          IPC = 32'h1111_3000, IST = 32'h1111_4000;
  localparam int FRP [12] = '{27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 0, 21};
  localparam int PMP [15] = '{2, 1, 0, 27, 26, 25, 24, 31, 30, 29, 28, 23, 22, 20, 21};

  always #4 clk = ~clk;
  assign rf_data = 32'hA500_0000 | {27'd0, rf_addr};

  regpush_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .list_word(list_word),
    .sp_in(sp_in), .in_fatal(in_fatal), .in_exc(in_exc), .stat_word(STATW),
    .fatal_ret_pc(FPC), .fatal_ret_stat(FST), .intr_ret_pc(IPC), .intr_ret_stat(IST),
    .rf_addr(rf_addr), .rf_data(rf_data), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .busy(busy), .done(done), .sp_out(sp_out));

  int n_chk = 0, n_fail = 0;
  logic [31:0] got_a [40], got_d [40], exp_a [20], exp_d [20];
  int got_n = 0, exp_n = 0, done_cnt = 0, stall_err = 0, rmode = 0, rcnt = 0;
  logic hold_p = 0;
  logic [31:0] h_a, h_d;

  always @(posedge clk) begin
    if (hold_p && (!st_valid || st_addr !== h_a || st_data !== h_d)) stall_err++;
    hold_p = st_valid && !st_ready; h_a = st_addr; h_d = st_data;
    if (st_valid && st_ready && got_n < 40) begin got_a[got_n] = st_addr; got_d[got_n] = st_data; got_n++; end
    if (done) done_cnt++;
  end

  always @(negedge clk) begin
    rcnt++;
    st_ready <= (rmode == 0) || (rcnt % 4 == 3);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", req, act, expv); end
  endtask

  task automatic push_exp(input logic [31:0] a, input logic [31:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic run_op(input logic m, input logic [31:0] lw, input logic [31:0] sp,
                        input logic fat, input logic exc, input int rm, input bit restart,
                        input string req, output logic [31:0] exp_sp);
    logic [31:0] s;
    int cyc;
    s = sp; exp_n = 0;
    if (!m) begin
      for (int i = 0; i < 12; i++) if (lw[FRP[i]]) begin s -= 4; push_exp(s, 32'hA500_0000 | (20 + i)); end
      exp_sp = s - {25'd0, lw[5:1], 2'b00};
    end else begin
      for (int i = 0; i < 15; i++) if (lw[PMP[i]]) begin s -= 4; push_exp(s & ~32'd3, 32'hA500_0000 | (1 + i)); end
      if (lw[3]) begin s -= 4; push_exp(s & ~32'd3, STATW); end
      if (lw[19]) begin
        s -= 4; push_exp(s & ~32'd3, (fat && !exc) ? FPC : IPC);
        s -= 4; push_exp(s & ~32'd3, (fat && !exc) ? FST : IST);
      end
      exp_sp = s;
    end
    rmode = rm;
    @(negedge clk);
    got_n = 0; done_cnt = 0; stall_err = 0;
    mode = m; list_word = lw; sp_in = sp; in_fatal = fat; in_exc = exc; start = 1;
    @(negedge clk); start = 0; cyc = 0;
    while (!done && cyc < 500) begin
      if (restart && cyc == 1) begin
        start = 1; mode = ~m; list_word = 32'hFFFF_FFFF; sp_in = 32'h7777_0000;
      end else start = 0;
      @(negedge clk); cyc++;
    end
    start = 0;
    chk(done === 1'b1, req, {31'd0, done}, 1);
    if (exp_n == 0) chk(cyc <= 1, "R9 done latency", cyc, 1);
    chk(sp_out === exp_sp, req, sp_out, exp_sp);
    @(negedge clk);
    chk(done === 1'b0 && sp_out === exp_sp, "R12 pulse/hold", {31'd0, done}, 0);
    chk(done_cnt == 1, "R11/R12 done count", done_cnt, 1);
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_a[k] === exp_a[k], req, got_a[k], exp_a[k]);
      chk(got_d[k] === exp_d[k], req, got_d[k], exp_d[k]);
    end
    chk(stall_err == 0, "R10 stall hold", stall_err, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !st_valid && got_n == exp_n, "R11 idle after", got_n, exp_n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !st_valid, "R12 reset", {29'd0, busy, done, st_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !st_valid, "R12 idle", {29'd0, busy, done, st_valid}, 0);
  endtask

  task automatic t_frame_mix();
    logic [31:0] e;
    run_op(0, 32'h8A20_000B, 32'h0000_2000, 0, 0, 0, 0, "R1/R2/R3 frame mix", e);
  endtask

  task automatic t_frame_full_stall();
    logic [31:0] e;
    run_op(0, 32'hFFE0_003F, 32'h0000_1002, 0, 0, 1, 0, "R3 frame full unaligned", e);
  endtask

  task automatic t_push_subset();
    logic [31:0] e;
    run_op(1, 32'h0020_0005, 32'h0000_4000, 0, 0, 0, 0, "R4 push subset", e);
  endtask

  task automatic t_push_all_fatal();
    logic [31:0] e;
    run_op(1, 32'hFFF8_000F, 32'h0000_2003, 1, 0, 1, 0, "R5/R6/R7/R8 push all fatal", e);
  endtask

  task automatic t_pair_intr();
    logic [31:0] e;
    run_op(1, 32'h0008_0000, 32'h0000_3000, 1, 1, 0, 0, "R7 pair fatal+exc", e);
    run_op(1, 32'h0008_0008, 32'h0000_3001, 0, 0, 0, 0, "R6/R7 pair none", e);
  endtask

  task automatic t_empty();
    logic [31:0] e;
    run_op(0, 32'h0000_003E, 32'h0000_5000, 0, 0, 0, 0, "R9 empty frame", e);
    chk(e == 32'h0000_5000 - 124, "R9 imm value", e, 32'h0000_5000 - 124);
    run_op(1, 32'h0000_0000, 32'h0000_5003, 0, 0, 0, 0, "R9 empty push", e);
  endtask

  task automatic t_restart_busy();
    logic [31:0] e;
    run_op(1, 32'h0000_0007, 32'h0000_6000, 0, 0, 1, 1, "R11 start while busy", e);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame_mix();
    t_frame_full_stall();
    t_push_subset();
    t_push_all_fatal();
    t_pair_intr();
    t_empty();
    t_restart_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule